// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto a small number of shared bus interrupt lines. Every slot carries four request pins. Pin `p` of slot `s` is routed to bus line `(s + p) mod N_LINES`, so neighbouring slots rotate their pins across the lines and the load is spread evenly.

A shared line does not come from a wide OR gate. The block keeps a counter for each line that holds the number of routed pins that are currently high. It also remembers the last level of every pin. A counter moves only when a pin's level differs from the remembered one. All rising and falling edges that reach one line in the same cycle are summed into a single update of its counter. The line output is a register that is high while its counter is nonzero. A request therefore reaches its line one clock after it is sampled.

Top module: `irq_line_aggregator`

## Requirements
- R1: While `rst` is high, every line output is 0, every counter is cleared and every remembered pin level is cleared. A pin that is high when reset is released counts as a rising edge, so its line goes high one cycle later.
- R2: Pin `p` of slot `s` sits at bit `4*s + p` of `pin_req` and drives only line `(s + p) mod N_LINES`, which is bit index `(s + p) mod N_LINES` of `line_out`.
- R3: A line output is 1 exactly when at least one pin routed to it was high in the previous cycle.
- R4: A line stays high while any routed pin is still high, whatever the order in which the other routed pins drop. It goes low only after the last one has dropped.
- R5: Rising and falling edges on pins that share a line in the same cycle are summed before the counter is updated. For example, one pin dropping while another rises keeps the line high.
- R6: A change of `pin_req` reaches `line_out` after exactly one rising clock edge, and not before that edge.
- R7: A counter holds up to 4 x N_SLOTS raised pins without overflow. With every pin high, every line is high. Dropping all pins but one leaves only that pin's line high.
- R8: A pin held at a constant level does not move any counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pin_req | input | 4*N_SLOTS | Level request of pin p of slot s at bit 4*s+p |
| line_out | output | N_LINES | Registered level of each shared bus line |

## Verification
A counter that is off by one shows up at the ports in a particular way. The line stays high after its last routed pin drops, or it falls while one pin is still raised. Either fault appears on the first cycle after the affected release, and it persists for as long as the wrong count stays in place. The bench therefore drops shared pins in different orders and swaps edges within a single cycle. An error in the remembered pin levels shows as a stuck or missing line just after reset, which is why some pins are held high across the release of reset. A routing error lights the wrong bit one cycle after a single pin is raised.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int PINS_PER_SLOT = 4;

    function automatic int line_of(input int slot, input int pin, input int n_lines);
        return (slot + pin) % n_lines;
    endfunction

endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
    parameter int NPINS = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] req,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);

    typedef struct packed {
        logic [NPINS-1:0] lvl;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = req;
        rise     = req & ~st_q.lvl;
        fall     = ~req & st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_line_delta.sv
module irq_line_delta
    import irq_aggr_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int N_LINES = 4,
    parameter int CW      = 8
) (
    input  logic [N_SLOTS*PINS_PER_SLOT-1:0] rise,
    input  logic [N_SLOTS*PINS_PER_SLOT-1:0] fall,
    output logic [N_LINES*CW-1:0]            up_flat,
    output logic [N_LINES*CW-1:0]            dn_flat
);

    localparam int NPINS = N_SLOTS * PINS_PER_SLOT;

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        logic [CW-1:0] up_l, dn_l;

        always_comb begin
            up_l = '0;
            dn_l = '0;
            for (int i = 0; i < NPINS; i++) begin
                if (line_of(i / PINS_PER_SLOT, i % PINS_PER_SLOT, N_LINES) == l) begin
                    if (rise[i]) up_l = up_l + CW'(1);
                    if (fall[i]) dn_l = dn_l + CW'(1);
                end
            end
        end

        assign up_flat[l*CW +: CW] = up_l;
        assign dn_flat[l*CW +: CW] = dn_l;
    end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] up,
    input  logic [CW-1:0] dn,
    output logic [CW-1:0] count,
    output logic          level
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + up - dn;
        st_d.lvl = (st_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign level = st_q.lvl;

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
    import irq_aggr_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int N_LINES = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N_SLOTS*PINS_PER_SLOT-1:0] pin_req,
    output logic [N_LINES-1:0]               line_out
);

    localparam int NPINS = N_SLOTS * PINS_PER_SLOT;
    localparam int CW    = $clog2(NPINS + 1);

    logic [NPINS-1:0]     rise, fall;
    logic [N_LINES*CW-1:0] up_flat, dn_flat, cnt_flat;

    irq_pin_tracker #(.NPINS(NPINS)) u_trk (
        .clk  (clk),
        .rst  (rst),
        .req  (pin_req),
        .rise (rise),
        .fall (fall)
    );

    irq_line_delta #(.N_SLOTS(N_SLOTS), .N_LINES(N_LINES), .CW(CW)) u_delta (
        .rise    (rise),
        .fall    (fall),
        .up_flat (up_flat),
        .dn_flat (dn_flat)
    );

    for (genvar l = 0; l < N_LINES; l++) begin : g_cnt
        irq_line_counter #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .up    (up_flat[l*CW +: CW]),
            .dn    (dn_flat[l*CW +: CW]),
            .count (cnt_flat[l*CW +: CW]),
            .level (line_out[l])
        );
    end

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
    parameter int NPINS   = 128,
    parameter int N_LINES = 4,
    parameter int CW      = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NPINS-1:0]      pin_req,
    input logic [N_LINES-1:0]    line_out,
    input logic [N_LINES*CW-1:0] cnt_flat
);

    // R3
    all_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_req == '0) |=> (line_out == '0));

    // R8
    held_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(pin_req)) |=> $stable(cnt_flat));

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        // R7
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            cnt_flat[l*CW +: CW] <= CW'(NPINS));

        // R4
        level_tracks_count_chk: assert property (@(posedge clk) disable iff (rst)
            line_out[l] == (cnt_flat[l*CW +: CW] != '0));
    end

endmodule

bind irq_line_aggregator irq_aggr_chk #(
    .NPINS   (NPINS),
    .N_LINES (N_LINES),
    .CW      (CW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_req  (pin_req),
    .line_out (line_out),
    .cnt_flat (cnt_flat)
);

// File: tb/test_irq_line_aggregator.sv
`timescale 1ns/1ps
module test_irq_line_aggregator;

    localparam int NS = 32;
    localparam int NL = 4;
    localparam int NP = NS * 4;

    typedef struct {
        logic [NL-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_req = '0;
    logic [NL-1:0] line_out;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    logic  [NL-1:0] last_exp = '0;

    always #2.5 clk = ~clk;

    irq_line_aggregator #(.N_SLOTS(NS), .N_LINES(NL)) i_irq_line_aggregator (
        .clk      (clk),
        .rst      (rst),
        .pin_req  (pin_req),
        .line_out (line_out)
    );

    function automatic logic [NL-1:0] model(input logic [NP-1:0] v);
        logic [NL-1:0] e = '0;
        for (int i = 0; i < NP; i++)
            if (v[i]) e[((i / 4) + (i % 4)) % NL] = 1'b1;
        return e;
    endfunction

    function automatic logic [NP-1:0] one_pin(input int s, input int p);
        logic [NP-1:0] v = '0;
        v[s*4 + p] = 1'b1;
        return v;
    endfunction

    task automatic check(input logic [NL-1:0] act, input logic [NL-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: line_out=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [NP-1:0] v, input string tag);
        item_t it;
        @(negedge clk);
        pin_req = v;
        it.exp = model(v);
        it.tag = tag;
        sb_q.push_back(it);
        last_exp = it.exp;
    endtask

    // monitor: one result per edge after each driven vector
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(line_out, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [NP-1:0] v;
        logic [31:0]   lfsr;

        // R1: pins held high during reset, outputs stay low
        pin_req = '1;
        repeat (3) @(posedge clk);
        #1 check(line_out, '0, "R1 reset holds lines low");
        @(posedge clk);
        #1 check(line_out, '0, "R1 reset holds lines low again");
        @(negedge clk);
        rst = 1'b0;
        begin
            item_t it;
            it.exp = '1;
            it.tag = "R1 held pins count as rises after reset";
            sb_q.push_back(it);
        end
        apply('0, "R1 release after reset");

        // R2: single pins across several slots
        foreach (v[k]) v[k] = 1'b0;
        for (int si = 0; si < 4; si++) begin
            int s;
            s = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 5 : 31;
            for (int p = 0; p < 4; p++) begin
                apply(one_pin(s, p), "R2 pin routing");
                apply('0, "R2 pin release");
            end
        end

        // R6: no change before the edge, change after it
        apply(one_pin(2, 1), "R6 rise seen after one edge");
        @(negedge clk);
        pin_req = '0;
        #1 check(line_out, 4'b1000, "R6 output unchanged before edge");
        @(posedge clk);
        #1 check(line_out, '0, "R6 fall seen after one edge");

        // R4: two pins on line 0, dropped in both orders
        apply(one_pin(0, 0) | one_pin(1, 3), "R4 two pins on line 0");
        apply(one_pin(1, 3), "R4 one dropped line still high");
        apply('0, "R4 last dropped line low");
        apply(one_pin(0, 0) | one_pin(1, 3), "R4 two pins again");
        apply(one_pin(0, 0), "R4 other order still high");
        apply(one_pin(0, 0), "R8 held pin no effect");
        apply('0, "R4 line low");

        // R5: swap within a cycle on a shared line
        apply(one_pin(3, 1), "R5 first pin raised");
        apply(one_pin(2, 2), "R5 swap keeps line high");
        apply(one_pin(4, 0) | one_pin(2, 2), "R5 add same line");
        apply(one_pin(4, 0), "R5 one left");
        apply('0, "R5 both cleared");
        apply(one_pin(0, 0) | one_pin(1, 3) | one_pin(2, 2), "R5 triple rise");
        apply('0, "R5 triple fall");

        // R7: full load
        apply('1, "R7 all pins high");
        apply('1, "R8 all held");
        apply(one_pin(31, 3), "R7 all but one released");
        apply('0, "R7 all low");

        // R3: pseudo-random patterns
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 60; n++) begin
            for (int w = 0; w < NP / 32; w++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                v[w*32 +: 32] = lfsr & {lfsr[15:0], lfsr[31:16]} & {lfsr[7:0], lfsr[31:8]};
            end
            if (n % 5 == 0) v = '0;
            apply(v, "R3 random pattern");
        end
        apply('0, "R3 final clear");

        repeat (3) @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule